// File: doc/BRIEF.md
# Bus-Matching Width Converter with Selectable Beat Order

This block joins a fixed 36-bit internal word path to an external beat port. The beat port can be 36, 18 or 9 bits wide. On the write side it collects narrow input beats and forms a full word. It hands that word onward through a push handshake. On the read side it takes one word through a pop handshake and sends it out again as a series of narrow beats.

The write width and the read width are chosen independently. A shared bus-matching enable and one narrowing select per side set them. A big- or little-endian setting picks the beat order. All of these settings are captured only while reset is held, so a port can change its shape only through a reset.

Both beat ports use a valid/ready handshake. The word side is a push (valid/ready) on the write path and a pop (valid/ready) on the read path. Each 9-bit lane keeps its top bit as a parity bit, which the converter passes through unchanged and never checks.

Top module: `bus_width_adapter`

## Requirements
- R1: While reset (`rst_n` low) is applied at a clock edge, the next cycle shows `in_ready`=1, `pop_ready`=1, `push_valid`=0 and `out_valid`=0.
- R2: Each side's width is 36 bits when `cfg_bus_match`=0. With `cfg_bus_match`=1, the width is 18 bits when that side's narrow select is 0 and 9 bits when it is 1. A word therefore takes 1, 2 or 4 beats.
- R3: The width and endian inputs are sampled only during reset. Changing them afterwards does not alter packing, unpacking or beat order.
- R4: In 18-bit mode `in_data[35:18]` is ignored, and in 9-bit mode `in_data[35:9]` is ignored; they act as zero.
- R5: With `cfg_little_endian`=0 latched (big-endian), the first write beat fills the most significant slice of the word, and each later beat fills the next lower slice.
- R6: With `cfg_little_endian`=1 latched (little-endian), the first write beat fills bits [w-1:0] of the word, and each later beat fills the next higher slice.
- R7: `push_valid` rises only once a whole word's beats have been accepted; a partial word is never pushed.
- R8: While `push_valid`=1 and `push_ready`=0, `push_valid` stays high, `push_data` holds its value, and `in_ready` stays low.
- R9: The read side emits one beat per word slice, in the same endian order as R5/R6. The beat sits in `out_data[w-1:0]` with the upper bits zero, and the beat holds while `out_ready` is low.
- R10: `pop_ready` is high only when no word is being unpacked. It returns high in the cycle after the last beat of a word is accepted.
- R11: Reset discards a partly packed word, and the next word is built only from beats accepted after reset.
- R12: Bit 8 of every 9-bit lane travels unchanged between the beat and its lane of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration sampled while low |
| cfg_bus_match | input | 1 | Enables narrow port widths (both sides) |
| cfg_wr_narrow | input | 1 | Write side: 0 = 18-bit, 1 = 9-bit when matching enabled |
| cfg_rd_narrow | input | 1 | Read side: 0 = 18-bit, 1 = 9-bit when matching enabled |
| cfg_little_endian | input | 1 | 0 = big-endian beat order, 1 = little-endian |
| in_valid | input | 1 | Write beat valid |
| in_ready | output | 1 | Write beat accepted when high with in_valid |
| in_data | input | 36 | Write beat data |
| push_valid | output | 1 | Complete packed word available |
| push_ready | input | 1 | Word sink accepts the word |
| push_data | output | 36 | Packed word |
| pop_valid | input | 1 | Word source offers a word |
| pop_ready | output | 1 | Converter takes the offered word |
| pop_data | input | 36 | Word to unpack |
| out_valid | output | 1 | Read beat valid |
| out_ready | input | 1 | Read beat consumer ready |
| out_data | output | 36 | Read beat data, upper bits zero when narrow |

## Verification
The bench builds the converter with its default 9-bit lane, which gives the 36-bit word and all three port shapes. That setting reaches every width on both sides in both beat orders, the 4-beat case where lane parity bits matter, and the 18-bit case where half of the input bus must be ignored. Every scenario drives beats whose unused upper bits carry random data. The expected words and beats come from a small slice model in the bench.

// File: rtl/bwa_pkg.sv
// Shared types and helpers for the bus-matching width converter.
// Assumes a word of exactly four lanes, so the narrow modes are half and quarter.
package bwa_pkg;
    localparam int LANES = 4;
    localparam int CNT_W = 2;

    typedef enum logic [1:0] {
        PW_FULL = 2'd0,
        PW_HALF = 2'd1,
        PW_QTR  = 2'd2
    } port_width_e;

    // Map the matching enable and a side's narrow select to a port width.
    function automatic port_width_e decode_width(input logic match_en, input logic narrow);
        if (!match_en) return PW_FULL;
        return narrow ? PW_QTR : PW_HALF;
    endfunction

    // Index of the final beat of a word for a given width.
    function automatic logic [CNT_W-1:0] last_beat(input port_width_e w);
        case (w)
            PW_FULL: return 2'd0;
            PW_HALF: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    // Word slice addressed by beat number cnt under the chosen order.
    function automatic logic [CNT_W-1:0] beat_slot(input port_width_e w, input logic little,
                                                   input logic [CNT_W-1:0] cnt);
        return little ? cnt : last_beat(w) - cnt;
    endfunction
endpackage

// File: rtl/bwa_cfg_latch.sv
// Captures the port widths and beat order while reset is low and holds them after.
// Assumes reset is held for at least one clock edge with stable configuration inputs.
module bwa_cfg_latch
    import bwa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_bus_match,
    input  logic        cfg_wr_narrow,
    input  logic        cfg_rd_narrow,
    input  logic        cfg_little_endian,
    output port_width_e wr_width,
    output port_width_e rd_width,
    output logic        little
);
    // Sample configuration only during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_width <= decode_width(cfg_bus_match, cfg_wr_narrow);
            rd_width <= decode_width(cfg_bus_match, cfg_rd_narrow);
            little   <= cfg_little_endian;
        end
    end
endmodule

// File: rtl/bwa_packer.sv
// Assembles narrow write beats into one full word, then offers it through a push handshake.
// Assumes the width and order inputs are static outside reset. Reset drops any partial word.
module bwa_packer
    import bwa_pkg::*;
#(
    parameter  int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W,
    localparam int HALF   = LANES / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_width_e       width,
    input  logic              little,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              push_valid,
    input  logic              push_ready,
    output logic [WORD_W-1:0] push_data
);
    logic             full_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] slot;
    logic             in_fire;

    assign in_ready   = !full_q;
    assign push_valid = full_q;
    assign in_fire    = in_valid && in_ready;
    assign slot       = beat_slot(width, little, cnt_q);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic              hit;
        logic [LANE_W-1:0] src;
        logic [LANE_W-1:0] lane_q;

        // Decide whether this lane is written by the current beat and from which input lane.
        always_comb begin
            unique case (width)
                PW_FULL: begin
                    hit = 1'b1;
                    src = in_data[j*LANE_W +: LANE_W];
                end
                PW_HALF: begin
                    hit = (slot == CNT_W'(j / HALF));
                    src = in_data[(j % HALF)*LANE_W +: LANE_W];
                end
                default: begin
                    hit = (slot == CNT_W'(j));
                    src = in_data[LANE_W-1:0];
                end
            endcase
        end

        // Hold this lane of the word being assembled.
        always_ff @(posedge clk) begin
            if (!rst_n)              lane_q <= '0;
            else if (in_fire && hit) lane_q <= src;
        end

        assign push_data[j*LANE_W +: LANE_W] = lane_q;
    end

    // Count beats and mark the word complete after its last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            cnt_q  <= '0;
        end else if (full_q) begin
            if (push_ready) full_q <= 1'b0;
        end else if (in_fire) begin
            if (cnt_q == last_beat(width)) begin
                full_q <= 1'b1;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bwa_unpacker.sv
// Takes one word through a pop handshake and emits it as narrow beats in the chosen order.
// Assumes the width and order inputs are static outside reset. Narrow beats are zero-extended.
module bwa_unpacker
    import bwa_pkg::*;
#(
    parameter  int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W,
    localparam int HALF   = LANES / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_width_e       width,
    input  logic              little,
    input  logic              pop_valid,
    output logic              pop_ready,
    input  logic [WORD_W-1:0] pop_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    logic              loaded_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  slot;
    logic [WORD_W-1:0] half_view;
    logic [WORD_W-1:0] qtr_view;

    assign pop_ready = !loaded_q;
    assign out_valid = loaded_q;
    assign slot      = beat_slot(width, little, cnt_q);
    assign half_view = word_q >> (LANE_W * HALF * int'(slot));
    assign qtr_view  = word_q >> (LANE_W * int'(slot));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Route the addressed slice to the low lanes and zero the rest.
        always_comb begin
            unique case (width)
                PW_FULL: out_data[i*LANE_W +: LANE_W] = word_q[i*LANE_W +: LANE_W];
                PW_HALF: out_data[i*LANE_W +: LANE_W] =
                             (i < HALF) ? half_view[i*LANE_W +: LANE_W] : '0;
                default: out_data[i*LANE_W +: LANE_W] =
                             (i == 0) ? qtr_view[LANE_W-1:0] : '0;
            endcase
        end
    end

    // Load a word when idle and step through its beats as they are taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
            cnt_q    <= '0;
            word_q   <= '0;
        end else if (!loaded_q) begin
            if (pop_valid) begin
                word_q   <= pop_data;
                loaded_q <= 1'b1;
                cnt_q    <= '0;
            end
        end else if (out_ready) begin
            if (cnt_q == last_beat(width)) begin
                loaded_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bus_width_adapter.sv
// Top of the bus-matching width converter: configuration latch, write packer, read unpacker.
// Assumes configuration inputs are stable while reset is low. The two paths are independent.
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter  int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bus_match,
    input  logic              cfg_wr_narrow,
    input  logic              cfg_rd_narrow,
    input  logic              cfg_little_endian,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              push_valid,
    input  logic              push_ready,
    output logic [WORD_W-1:0] push_data,
    input  logic              pop_valid,
    output logic              pop_ready,
    input  logic [WORD_W-1:0] pop_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    port_width_e wr_width;
    port_width_e rd_width;
    logic        little;

    bwa_cfg_latch u_cfg (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_bus_match     (cfg_bus_match),
        .cfg_wr_narrow     (cfg_wr_narrow),
        .cfg_rd_narrow     (cfg_rd_narrow),
        .cfg_little_endian (cfg_little_endian),
        .wr_width          (wr_width),
        .rd_width          (rd_width),
        .little            (little)
    );

    bwa_packer #(.LANE_W(LANE_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .width      (wr_width),
        .little     (little),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .push_valid (push_valid),
        .push_ready (push_ready),
        .push_data  (push_data)
    );

    bwa_unpacker #(.LANE_W(LANE_W)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .width     (rd_width),
        .little    (little),
        .pop_valid (pop_valid),
        .pop_ready (pop_ready),
        .pop_data  (pop_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );
endmodule

// File: rtl/bus_width_adapter_checker.sv
// Protocol and ordering properties for the width converter, bound to its top.
// Keeps its own beat counter so whole-word pushes are checked independently of the packer.
module bus_width_adapter_checker
    import bwa_pkg::*;
#(
    parameter  int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              push_valid,
    input logic              push_ready,
    input logic [WORD_W-1:0] push_data,
    input logic              pop_valid,
    input logic              pop_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input port_width_e       wr_width,
    input port_width_e       rd_width,
    input logic              little
);
    logic [2:0] seen_beats;

    // Count accepted write beats since the last word left.
    always_ff @(posedge clk) begin
        if (!rst_n)                        seen_beats <= '0;
        else if (push_valid && push_ready) seen_beats <= '0;
        else if (in_valid && in_ready)     seen_beats <= seen_beats + 3'd1;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!push_valid && !out_valid && in_ready && pop_ready));

    p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(wr_width) && $stable(rd_width) && $stable(little)));

    p_whole_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> (seen_beats == 3'(last_beat(wr_width)) + 3'd1));

    p_push_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready) |=> (push_valid && $stable(push_data) && !in_ready));

    p_beat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rd_width != PW_FULL) |-> (out_data[WORD_W-1:WORD_W/2] == '0));

    p_pop_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && pop_ready) |=> (out_valid && !pop_ready));
endmodule

bind bus_width_adapter bus_width_adapter_checker #(.LANE_W(LANE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_data  (push_data),
    .pop_valid  (pop_valid),
    .pop_ready  (pop_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .wr_width   (wr_width),
    .rd_width   (rd_width),
    .little     (little)
);

// File: tb/bus_width_adapter_bench.sv
`timescale 1ns/1ps
module bus_width_adapter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bus_match = 1'b0, cfg_wr_narrow = 1'b0, cfg_rd_narrow = 1'b0;
    logic        cfg_little_endian = 1'b0;
    logic        in_valid = 1'b0, push_ready = 1'b1, pop_valid = 1'b0, out_ready = 1'b0;
    logic [35:0] in_data = '0, pop_data = '0;
    logic        in_ready, push_valid, pop_ready, out_valid;
    logic [35:0] push_data, out_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    bus_width_adapter u_bus_width_adapter (
        .clk(clk), .rst_n(rst_n),
        .cfg_bus_match(cfg_bus_match), .cfg_wr_narrow(cfg_wr_narrow),
        .cfg_rd_narrow(cfg_rd_narrow), .cfg_little_endian(cfg_little_endian),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model: place write beats into word slices.
    function automatic logic [35:0] model_pack(input int w, input bit le, input logic [35:0] b [4]);
        logic [35:0] r = '0;
        int n = 36 / w;
        for (int k = 0; k < n; k++) begin
            int s = le ? k : n - 1 - k;
            for (int i = 0; i < w; i++) r[s*w + i] = b[k][i];
        end
        return r;
    endfunction

    // Reference model: extract read beat k of a word.
    function automatic logic [35:0] model_beat(input int w, input bit le, input logic [35:0] wd, input int k);
        logic [35:0] r = '0;
        int n = 36 / w;
        int s = le ? k : n - 1 - k;
        for (int i = 0; i < w; i++) r[i] = wd[s*w + i];
        return r;
    endfunction

    task automatic do_reset(input int ww, input int rw, input bit le);
        @(negedge clk);
        cfg_bus_match     = (ww != 36) || (rw != 36);
        cfg_wr_narrow     = (ww == 9);
        cfg_rd_narrow     = (rw == 9);
        cfg_little_endian = le;
        in_valid = 0; pop_valid = 0; out_ready = 0; push_ready = 1;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        check(in_ready && pop_ready && !push_valid && !out_valid, "R1 reset idle",
              {32'd0, in_ready, pop_ready, push_valid, out_valid}, 36'hC);
    endtask

    task automatic send_beat(input logic [35:0] d);
        in_valid = 1; in_data = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic send_word(input int w, input logic [35:0] b [4]);
        int n = 36 / w;
        for (int k = 0; k < n; k++) begin
            send_beat(b[k]);
            if (k < n - 1)
                check(!push_valid, "R7 no push on partial word", {35'd0, push_valid}, 36'd0);
        end
    endtask

    task automatic rand_beats(output logic [35:0] b [4]);
        for (int k = 0; k < 4; k++) b[k] = 36'({$urandom(), $urandom()});
    endtask

    // Pack one word at width w and order le; upper input bits carry random data.
    task automatic t_pack(input int w, input bit le);
        logic [35:0] b [4];
        logic [35:0] exp;
        do_reset(w, 36, le);
        rand_beats(b);
        exp = model_pack(w, le, b);
        send_word(w, b);
        check(push_valid, "R2/R7 push after last beat", {35'd0, push_valid}, 36'd1);
        check(push_data == exp, le ? "R6/R4/R2 little pack" : "R5/R4/R2 big pack", push_data, exp);
        @(negedge clk);
        check(!push_valid && in_ready, "R2 word handed off", {34'd0, push_valid, in_ready}, 36'd1);
    endtask

    // Unpack one word at width w and order le.
    task automatic t_unpack(input int w, input bit le);
        logic [35:0] wd = 36'({$urandom(), $urandom()});
        int n = 36 / w;
        do_reset(36, w, le);
        pop_valid = 1; pop_data = wd;
        while (!pop_ready) @(negedge clk);
        @(negedge clk);
        pop_valid = 0;
        out_ready = 1;
        for (int k = 0; k < n; k++) begin
            logic [35:0] e = model_beat(w, le, wd, k);
            check(out_valid && out_data == e, "R9 unpacked beat order", out_data, e);
            check(!pop_ready, "R10 busy while unpacking", {35'd0, pop_ready}, 36'd0);
            @(negedge clk);
        end
        out_ready = 0;
        check(!out_valid && pop_ready, "R10 free after last beat", {34'd0, out_valid, pop_ready}, 36'd1);
    endtask

    // Hold a packed word with push_ready low and confirm it waits.
    task automatic t_push_stall();
        logic [35:0] b [4];
        logic [35:0] exp;
        do_reset(9, 36, 0);
        rand_beats(b);
        exp = model_pack(9, 0, b);
        push_ready = 0;
        send_word(9, b);
        repeat (3) @(negedge clk);
        check(push_valid && !in_ready && push_data == exp, "R8 stalled word held", push_data, exp);
        push_ready = 1;
        @(negedge clk);
        check(!push_valid && in_ready, "R8 released", {34'd0, push_valid, in_ready}, 36'd1);
    endtask

    // Configuration inputs moved after reset must not change the packing.
    task automatic t_cfg_frozen();
        logic [35:0] b [4];
        logic [35:0] exp;
        do_reset(18, 36, 0);
        cfg_wr_narrow = 1; cfg_little_endian = 1; cfg_bus_match = 1;
        rand_beats(b);
        exp = model_pack(18, 0, b);
        send_word(18, b);
        check(push_valid && push_data == exp, "R3 config frozen after reset", push_data, exp);
        @(negedge clk);
    endtask

    // A reset in mid-word drops the partial beats.
    task automatic t_partial_reset();
        logic [35:0] b [4];
        logic [35:0] exp;
        do_reset(9, 36, 1);
        send_beat(36'hFFFFFFFFF);
        send_beat(36'hFFFFFFFFF);
        do_reset(9, 36, 1);
        rand_beats(b);
        exp = model_pack(9, 1, b);
        send_word(9, b);
        check(push_valid && push_data == exp, "R11 partial word discarded", push_data, exp);
        @(negedge clk);
    endtask

    // Lane parity bits survive packing and unpacking.
    task automatic t_parity();
        logic [35:0] b [4];
        b[0] = 36'h100; b[1] = 36'h0; b[2] = 36'h100; b[3] = 36'h0;
        do_reset(9, 9, 1);
        send_word(9, b);
        check(push_data == 36'h004000100, "R12 lane parity bits packed", push_data, 36'h004000100);
        @(negedge clk);
        pop_valid = 1; pop_data = 36'h100000100;
        @(negedge clk);
        pop_valid = 0; out_ready = 1;
        check(out_data == 36'h100, "R12 parity beat 0", out_data, 36'h100);
        @(negedge clk);
        check(out_data == 36'h000, "R12 parity beat 1", out_data, 36'h000);
        repeat (2) @(negedge clk);
        out_ready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int le = 0; le < 2; le++) begin
            t_pack(36, le[0]); t_pack(18, le[0]); t_pack(9, le[0]);
            t_unpack(36, le[0]); t_unpack(18, le[0]); t_unpack(9, le[0]);
        end
        t_push_stall();
        t_cfg_frozen();
        t_partial_reset();
        t_parity();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule